// File: doc/BRIEF.md
# Four-Mode Word Shifter

This block shifts a word operand in one of four ways: logical right, arithmetic right, logical left and rotate left. An execution pipeline uses it to carry out the shift opcodes. The caller supplies the opcode, a 5-bit count taken from the instruction word, the operand to be shifted, and the low five bits of a second register. The count comes from the instruction field unless that field is zero. In that case the low bits of the second register set the count. No separate select bit exists.

The datapath is combinational. A single output register holds each result. Operations enter and leave over valid/ready handshakes. The unit accepts an operation when `in_valid` and `in_ready` are both high at a rising clock edge. The result appears on the next edge. It stays on `out_result` with `out_valid` high until the consumer raises `out_ready`. While the output register holds a result that has not been taken and `out_ready` is low, `in_ready` is low, so a new operation can never overwrite it. When `out_ready` is high, a new operation can enter in the same cycle that the old result leaves, so the unit can take one operation per cycle.

Top module: `shift_unit`

## Requirements
- R1: Opcode values select the mode: 26 is logical right, 27 is arithmetic right, 28 is logical left, 29 is rotate left. Any other opcode returns the operand unchanged.
- R2: The shift count n is `in_imm_cnt` when that field is nonzero. When it is zero, n is `in_reg_cnt`.
- R3: A logical right shift gives n zero bits at the top, followed by operand bits 31 down to n.
- R4: An arithmetic right shift gives n copies of operand bit 31, followed by operand bits 31 down to n. For example, a count of 13 on 0x8000_1234 gives 0xFFFC_0000.
- R5: A left shift puts operand bits 31-n down to 0 at the top and fills the low n bits with zero.
- R6: A rotate puts operand bits 31-n down to 0 above operand bits 31 down to 32-n. Bits that leave the top come back in at the bottom.
- R7: When n is zero, every mode returns the operand unchanged.
- R8: After an operation is accepted on a clock edge, `out_valid` is high and `out_result` holds its result from that edge onward.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_result` does not change. Otherwise `in_ready` is high. `out_valid` drops after a transfer that has no new operation behind it.
- R10: While `rst_n` is low, the unit clears `out_valid` and `out_result` to zero on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| in_opcode | input | 5 | Operation code |
| in_imm_cnt | input | 5 | Count field from the instruction |
| in_operand | input | 32 | Word to be shifted |
| in_reg_cnt | input | 5 | Low five bits of the count register |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 32 | Shifted word |

## Verification
Each result is due exactly one rising edge after its operation is accepted. That edge is also where `out_valid` must rise. `in_ready` is a combinational function of the current output state and `out_ready`, so it is due in the same cycle. The bench drives its inputs and compares on the falling edge. It keeps a cycle-accurate model that advances on the same rising edges as the unit, so each expected value is compared in the half-cycle after the edge that produces it. Held results under back-pressure are compared again on every cycle that they are held.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int unsigned OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_SRL = 5'd26;
  localparam logic [OPC_W-1:0] OPC_SRA = 5'd27;
  localparam logic [OPC_W-1:0] OPC_SHL = 5'd28;
  localparam logic [OPC_W-1:0] OPC_ROT = 5'd29;

  typedef enum logic [2:0] {
    MODE_PASS = 3'd0,
    MODE_SRL  = 3'd1,
    MODE_SRA  = 3'd2,
    MODE_SHL  = 3'd3,
    MODE_ROT  = 3'd4
  } shift_mode_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [CW-1:0]    imm_cnt,
  input  logic [CW-1:0]    reg_cnt,
  output shift_mode_e      mode,
  output logic [CW-1:0]    amount
);
  // An all-zero count field defers the count to the register operand.
  always_comb begin
    amount = (imm_cnt != '0) ? imm_cnt : reg_cnt;
    unique case (opcode)
      OPC_SRL: mode = MODE_SRL;
      OPC_SRA: mode = MODE_SRA;
      OPC_SHL: mode = MODE_SHL;
      OPC_ROT: mode = MODE_ROT;
      default: mode = MODE_PASS;
    endcase
  end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
  import shift_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input  shift_mode_e    mode,
  input  logic [CW-1:0]  amount,
  input  logic [W-1:0]   operand,
  output logic [W-1:0]   result
);
  logic [W-1:0] stage [0:CW];
  logic         fill;

  assign fill     = (mode == MODE_SRA) ? operand[W-1] : 1'b0;
  assign stage[0] = operand;

  // Stage k moves the word by 2**k places when count bit k is set.
  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    always_comb begin
      stage[k+1] = stage[k];
      if (amount[k]) begin
        unique case (mode)
          MODE_SRL, MODE_SRA:
            stage[k+1] = {{S{fill}}, stage[k][W-1:S]};
          MODE_SHL:
            stage[k+1] = {stage[k][W-1-S:0], {S{1'b0}}};
          MODE_ROT:
            stage[k+1] = {stage[k][W-1-S:0], stage[k][W-1:W-S]};
          default:
            stage[k+1] = stage[k];
        endcase
      end
    end
  end

  assign result = stage[CW];
endmodule

// File: rtl/shift_out_stage.sv
module shift_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_opcode,
  input  logic [CW-1:0]    in_imm_cnt,
  input  logic [W-1:0]     in_operand,
  input  logic [CW-1:0]    in_reg_cnt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result
);
  shift_mode_e   mode;
  logic [CW-1:0] amount;
  logic [W-1:0]  shifted;

  shift_decode #(.CW(CW)) u_decode (
    .opcode  (in_opcode),
    .imm_cnt (in_imm_cnt),
    .reg_cnt (in_reg_cnt),
    .mode    (mode),
    .amount  (amount)
  );

  shift_barrel #(.W(W), .CW(CW)) u_barrel (
    .mode    (mode),
    .amount  (amount),
    .operand (in_operand),
    .result  (shifted)
  );

  shift_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (shifted),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_result)
  );
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk
  import shift_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OPC_W-1:0] in_opcode,
  input logic [CW-1:0]    in_imm_cnt,
  input logic [W-1:0]     in_operand,
  input logic [CW-1:0]    in_reg_cnt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_result == '0));

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R9
  block_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_imm_cnt == '0 && in_reg_cnt == '0) |=> out_result == $past(in_operand));

  // R3
  srl_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_SRL && in_imm_cnt != '0) |=> !out_result[W-1]);

  // R4
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_SRA) |=> out_result[W-1] == $past(in_operand[W-1]));

  // R5
  shl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_SHL && in_imm_cnt != '0) |=> !out_result[0]);

  // R6
  rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_ROT) |=> $countones(out_result) == $countones($past(in_operand)));
endmodule

bind shift_unit shift_unit_chk #(.W(W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_imm_cnt (in_imm_cnt),
  .in_operand (in_operand),
  .in_reg_cnt (in_reg_cnt),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_opcode = '0;
  logic [4:0]  in_imm_cnt = '0;
  logic [31:0] in_operand = '0;
  logic [4:0]  in_reg_cnt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        m_valid = 1'b0;
  logic [31:0] m_result = '0;
  string       m_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_imm_cnt(in_imm_cnt), .in_operand(in_operand),
    .in_reg_cnt(in_reg_cnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  function automatic logic [31:0] ref_shift(input logic [4:0] op, input logic [4:0] imm,
                                            input logic [31:0] x, input logic [4:0] rc);
    int n;
    n = (imm != 0) ? int'(imm) : int'(rc);
    case (op)
      5'd26: return x >> n;
      5'd27: return 32'($signed(x) >>> n);
      5'd28: return x << n;
      5'd29: return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
      default: return x;
    endcase
  endfunction

  function automatic string ref_tag(input logic [4:0] op, input logic [4:0] imm,
                                    input logic [4:0] rc);
    if (op < 5'd26 || op > 5'd29) return "R1";
    if (imm == 0 && rc == 0) return "R7";
    if (imm == 0) return "R2";
    case (op)
      5'd26: return "R3";
      5'd27: return "R4";
      5'd28: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Cycle model of the handshake rules (R8, R9, R10).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_result <= '0;
      m_tag    <= "R10";
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid  <= 1'b1;
      m_result <= ref_shift(in_opcode, in_imm_cnt, in_operand, in_reg_cnt);
      m_tag    <= ref_tag(in_opcode, in_imm_cnt, in_reg_cnt);
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R9", 32'(in_ready), 32'(!m_valid || out_ready));
    check("R8", 32'(out_valid), 32'(m_valid));
    if (m_valid) check(m_tag, out_result, m_result);
  endtask

  task automatic step(input bit v, input logic [4:0] op, input logic [4:0] imm,
                      input logic [31:0] x, input logic [4:0] rc, input bit rdy);
    @(negedge clk);
    compare();
    in_valid   = v;
    in_opcode  = op;
    in_imm_cnt = imm;
    in_operand = x;
    in_reg_cnt = rc;
    out_ready  = rdy;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", 32'(out_valid), 32'd0);
    check("R10", out_result, 32'd0);
    rst_n = 1'b1;

    step(1, 5'd27, 5'd13, 32'h8000_1234, 5'd0, 1);  // R4 example
    step(1, 5'd26, 5'd4,  32'hF000_000F, 5'd0, 1);  // R3
    step(1, 5'd28, 5'd8,  32'h1234_5678, 5'd0, 1);  // R5
    step(1, 5'd29, 5'd4,  32'hA000_0005, 5'd0, 1);  // R6
    step(1, 5'd29, 5'd31, 32'h8000_0001, 5'd0, 1);  // R6 extreme
    step(1, 5'd26, 5'd0,  32'h8000_0000, 5'd31, 1); // R2 register count
    step(1, 5'd27, 5'd0,  32'h8765_4321, 5'd0, 1);  // R7
    step(1, 5'd29, 5'd0,  32'hDEAD_BEEF, 5'd0, 1);  // R7
    step(1, 5'd28, 5'd3,  32'h0000_0001, 5'd20, 1); // R2 immediate wins
    step(1, 5'd12, 5'd7,  32'hCAFE_F00D, 5'd3, 1);  // R1 other opcode
    step(1, 5'd28, 5'd1,  32'hFFFF_FFFF, 5'd0, 0);  // R9 back-pressure
    step(1, 5'd26, 5'd1,  32'h1111_1111, 5'd0, 0);
    step(1, 5'd26, 5'd2,  32'h2222_2222, 5'd0, 0);
    step(1, 5'd26, 5'd3,  32'h3333_3333, 5'd0, 1);
    step(0, 5'd0,  5'd0,  32'h0,         5'd0, 1);
    step(0, 5'd0,  5'd0,  32'h0,         5'd0, 1);

    for (int i = 0; i < 600; i++) begin
      logic [4:0] op;
      int sel;
      sel = $urandom_range(0, 5);
      op  = (sel < 4) ? 5'(26 + sel) : 5'($urandom_range(0, 31));
      step($urandom_range(0, 3) != 0, op,
           ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom),
           $urandom, 5'($urandom), $urandom_range(0, 3) != 0);
    end
    step(0, 5'd0, 5'd0, 32'h0, 5'd0, 1);
    step(0, 5'd0, 5'd0, 32'h0, 5'd0, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule